// File: doc/BRIEF.md
# Sliding Neighbourhood Window Generator

This block turns a raster-ordered stream of 8-bit pixels into a stream of V×H pixel neighbourhoods, one neighbourhood per image pixel, ready for a convolution stage downstream. Each neighbourhood is centred on one output pixel. Any position that falls outside the image reads as zero. The block keeps the V−1 most recent complete rows in separate line memories, one per row, so that all of them are read in the same cycle as a new pixel arrives. A V-tall column is then pushed into an H-wide shift register.

Both the pixel input and the window output are valid/ready streams. A pixel transfers on a rising edge where `in_valid` and `in_ready` are both high. A window transfers on a rising edge where `out_valid` and `out_ready` are both high. While a window waits with `out_ready` low, the block stops: `in_ready` drops and the held window does not change. Width and height are plain inputs that are sampled when a frame begins. After the last pixel of each row the block runs (H−1)/2 flush steps, and after the last row it runs (V−1)/2 flush rows. It accepts no pixels during these steps and completes the border windows. It then returns to the start of the next frame.

Top module: `lbw_top`

## Requirements
- R1: Window element (i,j), at bits [(i·H+j)·8 +: 8], with i counting rows top to bottom and j counting columns left to right, equals the pixel at row r−(V−1)/2+i, column c−(H−1)/2+j of the window centred on (r,c).
- R2: Every window element whose position lies outside the image (row <0 or ≥height, column <0 or ≥width) is zero.
- R3: Each frame yields exactly width×height windows, with centres in raster order, and no further window follows until new pixels arrive.
- R4: A pixel is accepted only where it belongs to the current frame. `in_ready` is low during flush steps and while a window is held.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_win` stays unchanged.
- R6: With `out_ready` held high, `in_ready` is high at every in-image position. Over a frame, the only input stalls are the (height−1)·(H−1)/2 flush steps at the ends of the rows.
- R7: `cfg_width` and `cfg_height` are sampled at the first step of each frame. Frames follow one another without reset, and no data from an earlier frame appears in a window.
- R8: Line widths up to 1920 pixels are supported (parameter MAX_W default).
- R9: The first window appears once (V−1)/2 rows plus (H−1)/2+1 pixels have been accepted.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | CW | Frame width in pixels (≥1), sampled at frame start |
| cfg_height | input | RWD | Frame height in rows (≥1), sampled at frame start |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block accepts a pixel |
| in_pix | input | 8 | Input pixel |
| out_valid | output | 1 | Window valid |
| out_ready | input | 1 | Consumer accepts the window |
| out_win | output | V·H·8 | Window, element (i,j) at bits (i·H+j)·8 |

## Verification
Several internal faults would appear in the very next window that touches the affected state. A wrong line-memory shift would put the wrong row into the upper elements. A stale shift-register column would leak from one row into the next, or from one frame into the next, at the left or top border. A bad scan counter would place a window off centre or change the number of windows per frame. Each of these shows up when the window is compared, element by element, against pixels computed arithmetically. A handshake fault shows up within a cycle: the held window changes, or a junk pixel offered during flush gets accepted.

// File: rtl/lbw_pkg.sv
`timescale 1ns/1ps
package lbw_pkg;
  typedef logic [7:0] pix_t;

  function automatic int half_span(input int n);
    return (n - 1) / 2;
  endfunction
endpackage

// File: rtl/lbw_scan.sv
`timescale 1ns/1ps
module lbw_scan #(
  parameter int MAX_W = 1920,
  parameter int MAX_H = 1080,
  parameter int V     = 3,
  parameter int H     = 5,
  localparam int RV   = lbw_pkg::half_span(V),
  localparam int RH   = lbw_pkg::half_span(H),
  localparam int CW   = $clog2(MAX_W + RH + 1),
  localparam int RWD  = $clog2(MAX_H + RV + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  width_i,
  input  logic [RWD-1:0] height_i,
  input  logic           step,
  output logic [CW-1:0]  col,
  output logic [RWD-1:0] row,
  output logic [CW-1:0]  eff_w,
  output logic [RWD-1:0] eff_h,
  output logic           need_in,
  output logic           col_live,
  output logic           emit
);
  logic [CW-1:0]  w_q;
  logic [RWD-1:0] h_q;
  logic at_origin, last_col, last_row;

  always_comb begin
    at_origin = (col == '0) && (row == '0);
    eff_w     = at_origin ? width_i  : w_q;
    eff_h     = at_origin ? height_i : h_q;
    col_live  = col < eff_w;
    need_in   = col_live && (row < eff_h);
    emit      = (row >= RWD'(RV)) && (col >= CW'(RH));
    last_col  = col == (eff_w + CW'(RH) - CW'(1));
    last_row  = row == (eff_h + RWD'(RV) - RWD'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
      w_q <= '0;
      h_q <= '0;
    end else if (step) begin
      if (at_origin) begin
        w_q <= width_i;
        h_q <= height_i;
      end
      if (last_col) begin
        col <= '0;
        row <= last_row ? '0 : row + RWD'(1);
      end else begin
        col <= col + CW'(1);
      end
    end
  end

  // R3
  col_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_origin) |-> (col < w_q + CW'(RH)));

  // R3
  row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_origin) |-> (row < h_q + RWD'(RV)));
endmodule

// File: rtl/lbw_line.sv
`timescale 1ns/1ps
module lbw_line #(
  parameter int MAX_W = 1920,
  localparam int AW   = $clog2(MAX_W)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  lbw_pkg::pix_t din,
  output lbw_pkg::pix_t dout
);
  lbw_pkg::pix_t mem [MAX_W];

  assign dout = mem[addr];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= din;
  end
endmodule

// File: rtl/lbw_window.sv
`timescale 1ns/1ps
module lbw_window #(
  parameter int V   = 3,
  parameter int H   = 5,
  parameter int CW  = 11,
  parameter int RWD = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic             load,
  input  logic             col_live,
  input  logic [V*8-1:0]   newcol,
  input  logic [CW-1:0]    col,
  input  logic [RWD-1:0]   row,
  input  logic [CW-1:0]    eff_w,
  input  logic [RWD-1:0]   eff_h,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [V*H*8-1:0] out_win
);
  lbw_pkg::pix_t cols [H][V];
  lbw_pkg::pix_t nxt  [H][V];
  logic [V*H*8-1:0] win_n;

  always_comb begin
    for (int k = 0; k < V; k++) begin
      nxt[0][k] = col_live ? newcol[k*8 +: 8] : 8'h00;
    end
    for (int j = 1; j < H; j++) begin
      for (int k = 0; k < V; k++) begin
        nxt[j][k] = cols[j-1][k];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < V; i++) begin
      for (int j = 0; j < H; j++) begin
        int rr;
        int cc;
        rr = int'(row) - (V - 1) + i;
        cc = int'(col) - (H - 1) + j;
        if (rr >= 0 && rr < int'(eff_h) && cc >= 0 && cc < int'(eff_w))
          win_n[(i*H+j)*8 +: 8] = nxt[H-1-j][V-1-i];
        else
          win_n[(i*H+j)*8 +: 8] = 8'h00;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (shift) begin
      for (int j = 0; j < H; j++) begin
        for (int k = 0; k < V; k++) begin
          cols[j][k] <= nxt[j][k];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_win   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_win   <= win_n;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_win)));

  // R5
  win_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!out_valid || out_ready));
endmodule

// File: rtl/lbw_top.sv
`timescale 1ns/1ps
module lbw_top #(
  parameter int MAX_W = 1920,
  parameter int MAX_H = 1080,
  parameter int V     = 3,
  parameter int H     = 5,
  localparam int RV   = lbw_pkg::half_span(V),
  localparam int RH   = lbw_pkg::half_span(H),
  localparam int CW   = $clog2(MAX_W + RH + 1),
  localparam int RWD  = $clog2(MAX_H + RV + 1),
  localparam int AW   = $clog2(MAX_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    cfg_width,
  input  logic [RWD-1:0]   cfg_height,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_pix,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [V*H*8-1:0] out_win
);
  logic [CW-1:0]  col, eff_w;
  logic [RWD-1:0] row, eff_h;
  logic need_in, col_live, emit, hold, step;
  lbw_pkg::pix_t rd [V];
  logic [V*8-1:0] newcol;

  assign hold     = out_valid && !out_ready;
  assign step     = !hold && (!need_in || in_valid);
  assign in_ready = need_in && !hold;
  assign rd[0]    = need_in ? in_pix : 8'h00;

  lbw_scan #(.MAX_W(MAX_W), .MAX_H(MAX_H), .V(V), .H(H)) u_scan (
    .clk(clk), .rst_n(rst_n), .width_i(cfg_width), .height_i(cfg_height),
    .step(step), .col(col), .row(row), .eff_w(eff_w), .eff_h(eff_h),
    .need_in(need_in), .col_live(col_live), .emit(emit)
  );

  for (genvar k = 1; k < V; k++) begin : g_line
    lbw_line #(.MAX_W(MAX_W)) u_line (
      .clk(clk), .we(step && col_live), .addr(col[AW-1:0]),
      .din(rd[k-1]), .dout(rd[k])
    );
  end

  always_comb begin
    for (int k = 0; k < V; k++) newcol[k*8 +: 8] = rd[k];
  end

  lbw_window #(.V(V), .H(H), .CW(CW), .RWD(RWD)) u_win (
    .clk(clk), .rst_n(rst_n), .shift(step), .load(step && emit),
    .col_live(col_live), .newcol(newcol), .col(col), .row(row),
    .eff_w(eff_w), .eff_h(eff_h), .out_ready(out_ready),
    .out_valid(out_valid), .out_win(out_win)
  );

  // R4
  flush_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (row < eff_h));
endmodule

// File: tb/lbw_top_tb.sv
`timescale 1ns/1ps
module lbw_top_tb;
  localparam int V  = 3;
  localparam int H  = 5;
  localparam int RV = 1;
  localparam int RH = 2;
  localparam int WB = V*H*8;

  logic clk = 0, rst_n = 0;
  logic [10:0] cfg_width = 11'd7, cfg_height = 11'd5;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [7:0] in_pix = 0;
  logic [WB-1:0] out_win;
  int total = 0, bad = 0, cyc = 0;

  always #4 clk = ~clk;

  lbw_top #(.MAX_W(1920), .MAX_H(1080), .V(V), .H(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_win(out_win)
  );

  function automatic logic [7:0] pixv(int f, int r, int c);
    return 8'(((r*29 + c*11 + f*53) % 255) + 1);
  endfunction

  function automatic logic [WB-1:0] expw(int f, int w, int h, int r, int c);
    logic [WB-1:0] x;
    for (int i = 0; i < V; i++)
      for (int j = 0; j < H; j++) begin
        int rr = r - RV + i;
        int cc = c - RH + j;
        x[(i*H+j)*8 +: 8] = (rr >= 0 && rr < h && cc >= 0 && cc < w) ? pixv(f, rr, cc) : 8'h00;
      end
    return x;
  endfunction

  task automatic chk(bit ok, string req, logic [WB-1:0] act, logic [WB-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_frame(int f, int w, int h, bit gaps, bit thru, string tag);
    int in_idx = 0, out_idx = 0, stalls = 0, guard = 0;
    bit first = 0, prev_hold = 0;
    logic [WB-1:0] prev_win = '0;
    @(negedge clk);
    cfg_width = 11'(w);
    cfg_height = 11'(h);
    while (out_idx < w*h && guard < 30000) begin
      @(negedge clk);
      guard++; cyc++;
      out_ready = gaps ? (cyc % 3 != 1) : 1'b1;
      if (in_idx < w*h) begin
        in_valid = gaps ? (cyc % 5 != 2) : 1'b1;
        in_pix = pixv(f, in_idx / w, in_idx % w);
      end else if (w*h - out_idx >= 2) begin
        in_valid = 1'b1;
        in_pix = 8'hEE;
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (prev_hold)
        chk(out_valid && out_win == prev_win, "R5 held window", out_win, prev_win);
      prev_hold = out_valid && !out_ready;
      prev_win = out_win;
      if (out_valid && !first) begin
        first = 1;
        if (thru)
          chk(in_idx == RV*w + RH + 1, "R9 first-window lag", WB'(in_idx), WB'(RV*w + RH + 1));
      end
      if (out_valid && out_ready) begin
        logic [WB-1:0] e;
        int r = out_idx / w;
        int c = out_idx % w;
        e = expw(f, w, h, r, c);
        if (tag != "")
          chk(out_win == e, tag, out_win, e);
        else if (r < RV || c < RH || r + RV >= h || c + RH >= w)
          chk(out_win == e, "R2 padded window", out_win, e);
        else
          chk(out_win == e, "R1 interior window", out_win, e);
        out_idx++;
      end
      if (in_valid && in_ready) begin
        if (in_idx < w*h) in_idx++;
        else chk(0, "R4 pixel taken in flush", WB'(1), WB'(0));
      end
      if (thru && in_idx < w*h && !in_ready) stalls++;
    end
    if (guard >= 30000) chk(0, "watchdog", WB'(out_idx), WB'(w*h));
    if (thru) chk(stalls == (h-1)*RH, "R6 input stalls", WB'(stalls), WB'((h-1)*RH));
    @(negedge clk);
    in_valid = 0;
    out_ready = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      #1;
      chk(!out_valid, "R3 no extra window", WB'(out_valid), WB'(0));
    end
    chk(in_ready, "R7 ready for next frame", WB'(in_ready), WB'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk(!out_valid, "R10 out_valid after reset", WB'(out_valid), WB'(0));
    chk(in_ready, "R10 in_ready after reset", WB'(in_ready), WB'(1));
    run_frame(0, 7, 5, 0, 1, "");
    run_frame(1, 7, 5, 1, 0, "");
    run_frame(2, 1, 1, 0, 0, "R2 single pixel");
    run_frame(3, 2, 4, 1, 0, "R2 narrow frame");
    run_frame(4, 1920, 2, 0, 0, "R8 wide line");
    run_frame(5, 6, 3, 1, 0, "R7 back-to-back");
    run_frame(6, 5, 6, 1, 0, "R7 new size");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule